// File: doc/BRIEF.md
# Interrupt Status Unit with Read-to-Clear

This block is the interrupt collector of a two-wire serial bus controller. Single-cycle event pulses from the bus engine are captured into sticky status bits. Two further sources are not stored: they are recomputed every cycle by comparing the transmit and receive queue fill levels against thresholds that software programs. The raw status word is ANDed with a software mask to form the masked status. Any set bit of the masked status drives the interrupt line.

Software reaches the unit through a simple register bus. Sticky bits are never cleared by writes. Instead, software reads a clear address. One address drops every sticky bit. A separate address per source drops only that source's bit. A read request is accepted in the cycle it is presented, with no back-pressure. Its data comes back with a one-cycle valid strobe on the following cycle. Writes return nothing.

Register map (word addresses): 0 mask, 1 masked status, 2 raw status, 3 transmit threshold, 4 receive threshold, 8 clear-all, and 16+i the clear for source bit i (i = 0..11).

Top module: `irq_status_unit`

## Requirements
- R1: Bit positions of the status word are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop, 10 start, 11 general call. A one-cycle pulse on `evt_pulse[i]` sets sticky bit i, for every i except 2 and 4. The bit stays set until it is cleared by a read.
- R2: Raw bit 4 is 1 exactly while `tx_level` is less than or equal to the transmit threshold.
- R3: Raw bit 2 is 1 exactly while `rx_level` is greater than or equal to the receive threshold plus 1. The comparison does not wrap, so a threshold at the maximum level never asserts the bit.
- R4: The masked status (address 1) equals raw status AND mask. `irq_o` is the OR of the masked status. A mask of 0 holds `irq_o` low.
- R5: A read of address 8 clears all sticky bits. Bits 2 and 4 keep following their level conditions.
- R6: A read of address 16+i clears only sticky bit i. For i = 2 or i = 4 the read has no effect, because those bits are live levels.
- R7: Every clear read returns 0. It leaves the mask and both thresholds unchanged.
- R8: When a pulse for a bit arrives in the same cycle as a clear read covering that bit, the bit ends up set.
- R9: Pulses on `evt_pulse[2]` and `evt_pulse[4]` have no effect on the status.
- R10: After reset, the sticky bits, the mask and both thresholds are 0, and `bus_rvalid` is 0.
- R11: `bus_rvalid` rises exactly one cycle after a read request and stays low after a write. Raw and masked reads return the value that held in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 12 | One-cycle event pulses, one per status bit |
| tx_level | input | LVL_W | Current transmit queue fill level |
| rx_level | input | LVL_W | Current receive queue fill level |
| bus_req | input | 1 | Register access request, accepted in the same cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| irq_o | output | 1 | Interrupt line |

## Verification
The collision of interest is a fresh event pulse meeting a clear read in the same cycle, because both update the same sticky bit at one clock edge. The bench provokes this by raising the pulse and the clear read together in one cycle, for both the per-source clear and the clear-all. It then reads the raw status back and expects the pulsed bit to still be set. In the clear-all case, other sticky bits must have dropped.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 12;

  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_RD_REQ   = 5;
  localparam int B_TX_ABORT = 6;
  localparam int B_RX_DONE  = 7;
  localparam int B_ACTIVITY = 8;
  localparam int B_STOP     = 9;
  localparam int B_START    = 10;
  localparam int B_GEN_CALL = 11;

  localparam logic [NSRC-1:0] LEVEL_BITS  = (NSRC'(1) << B_RX_FULL) | (NSRC'(1) << B_TX_EMPTY);
  localparam logic [NSRC-1:0] STICKY_BITS = ~LEVEL_BITS;

  localparam int AD_MASK     = 0;
  localparam int AD_MSTAT    = 1;
  localparam int AD_RAW      = 2;
  localparam int AD_TX_TH    = 3;
  localparam int AD_RX_TH    = 4;
  localparam int AD_CLR_ALL  = 8;
  localparam int AD_CLR_BASE = 16;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
  import irq_pkg::*;
#(
  parameter int N = NSRC,
  parameter logic [N-1:0] KEEP = STICKY_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (KEEP[i]) begin : g_sticky
      logic q;
      // a new pulse overrides a clear landing in the same cycle
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (evt_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign lat_o[i] = q;
    end else begin : g_level
      logic unused_evt;
      logic unused_clr;
      assign unused_evt = evt_i[i];
      assign unused_clr = clr_i[i];
      assign lat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             tx_low,
  output logic             rx_high
);
  localparam int CW = LVL_W + 1;

  logic [CW-1:0] rx_lim;

  assign rx_lim  = {1'b0, rx_thresh} + CW'(1);
  assign tx_low  = (tx_level <= tx_thresh);
  assign rx_high = ({1'b0, rx_level} >= rx_lim);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
#(
  parameter int N      = NSRC,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N-1:0]      raw_i,
  output logic [N-1:0]      mask_o,
  output logic [LVL_W-1:0]  tx_th_o,
  output logic [LVL_W-1:0]  rx_th_o,
  output logic [N-1:0]      clr_o,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(AD_MASK);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(AD_MSTAT);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(AD_RAW);
  localparam logic [ADDR_W-1:0] A_TXTH  = ADDR_W'(AD_TX_TH);
  localparam logic [ADDR_W-1:0] A_RXTH  = ADDR_W'(AD_RX_TH);
  localparam logic [ADDR_W-1:0] A_CALL  = ADDR_W'(AD_CLR_ALL);
  localparam logic [ADDR_W-1:0] A_CBASE = ADDR_W'(AD_CLR_BASE);
  localparam logic [ADDR_W-1:0] A_CEND  = ADDR_W'(AD_CLR_BASE + N);

  logic              rd_en, wr_en, in_one;
  logic [ADDR_W-1:0] off;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wd;

  assign rd_en  = bus_req && !bus_we;
  assign wr_en  = bus_req && bus_we;
  assign off    = bus_addr - A_CBASE;
  assign in_one = (bus_addr >= A_CBASE) && (bus_addr < A_CEND);
  assign unused_wd = ^bus_wdata;

  always_comb begin
    clr_o = '0;
    if (rd_en && bus_addr == A_CALL) clr_o = '1;
    else if (rd_en && in_one)        clr_o = {{(N-1){1'b0}}, 1'b1} << off;
  end

  always_comb begin
    case (bus_addr)
      A_MASK:  rd_mux = DATA_W'(mask_o);
      A_MSTAT: rd_mux = DATA_W'(raw_i & mask_o);
      A_RAW:   rd_mux = DATA_W'(raw_i);
      A_TXTH:  rd_mux = DATA_W'(tx_th_o);
      A_RXTH:  rd_mux = DATA_W'(rx_th_o);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o  <= '0;
      tx_th_o <= '0;
      rx_th_o <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_MASK: mask_o  <= bus_wdata[N-1:0];
        A_TXTH: tx_th_o <= bus_wdata[LVL_W-1:0];
        A_RXTH: rx_th_o <= bus_wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o
);
  logic [NSRC-1:0]  lat_q, clr_vec, mask_q, raw_w, lvl_w;
  logic [LVL_W-1:0] tx_th_q, rx_th_q;
  logic             tx_low, rx_high;

  irq_latch_bank #(.N(NSRC), .KEEP(STICKY_BITS)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(clr_vec), .lat_o(lat_q)
  );

  irq_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .tx_level(tx_level), .tx_thresh(tx_th_q),
    .rx_level(rx_level), .rx_thresh(rx_th_q),
    .tx_low(tx_low), .rx_high(rx_high)
  );

  always_comb begin
    lvl_w = '0;
    lvl_w[B_TX_EMPTY] = tx_low;
    lvl_w[B_RX_FULL]  = rx_high;
  end

  assign raw_w = lat_q | lvl_w;
  assign irq_o = |(raw_w & mask_q);

  irq_regfile #(.N(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_i(raw_w), .mask_o(mask_q), .tx_th_o(tx_th_q), .rx_th_o(rx_th_q),
    .clr_o(clr_vec), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [NSRC-1:0]   evt_pulse,
  input logic [NSRC-1:0]   lat_q,
  input logic [NSRC-1:0]   clr_vec,
  input logic [NSRC-1:0]   mask_q,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  tx_th_q,
  input logic [NSRC-1:0]   raw_w,
  input logic              irq_o
);
  logic clr_rd;
  assign clr_rd = bus_req && !bus_we &&
                  (bus_addr == ADDR_W'(AD_CLR_ALL) ||
                   (bus_addr >= ADDR_W'(AD_CLR_BASE) && bus_addr < ADDR_W'(AD_CLR_BASE + NSRC)));

  a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(lat_q & ~clr_vec)) == $past(lat_q & ~clr_vec)));

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(evt_pulse & STICKY_BITS)) == $past(evt_pulse & STICKY_BITS)));

  a_r2_tx_empty_live: assert property (@(posedge clk) disable iff (!rst_n)
    raw_w[B_TX_EMPTY] == (tx_level <= tx_th_q));

  a_r4_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  a_r7_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> (bus_rvalid && bus_rdata == '0));

  a_r11_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_rvalid == $past(bus_req && !bus_we)));
endmodule

bind irq_status_unit irq_status_chk #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .evt_pulse(evt_pulse),
  .lat_q(lat_q), .clr_vec(clr_vec), .mask_q(mask_q), .tx_level(tx_level),
  .tx_th_q(tx_th_q), .raw_w(raw_w), .irq_o(irq_o)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int LVL_W = 7, ADDR_W = 6, DATA_W = 16, NV = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       evt_pulse = '0;
  logic [LVL_W-1:0]  tx_level = '0, rx_level = '0;
  logic              bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid, irq_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_status_unit #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .tx_level(tx_level), .rx_level(rx_level),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o)
  );

  // {event pulses, tx level, rx level, expected raw}; tx threshold 3, rx threshold 5
  localparam logic [37:0] VEC [NV] = '{
    {12'h001, 7'd0,  7'd0,   12'h011},
    {12'h800, 7'd4,  7'd6,   12'h804},
    {12'h0A0, 7'd3,  7'd5,   12'h0B0},
    {12'h014, 7'd10, 7'd0,   12'h000},
    {12'hFFF, 7'd10, 7'd0,   12'hFEB},
    {12'h348, 7'd64, 7'd64,  12'h34C},
    {12'h402, 7'd0,  7'd127, 12'h416},
    {12'h000, 7'd3,  7'd4,   12'h010}
  };

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input int a, input int d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input int a, output logic [DATA_W-1:0] d, output logic v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic clr_with_evt(input int a, input logic [11:0] e);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a); evt_pulse = e;
    @(negedge clk);
    bus_req = 1'b0; evt_pulse = '0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic v;
    repeat (3) @(negedge clk);
    chk("R10 rvalid in reset", DATA_W'(bus_rvalid), 0);
    rst_n = 1'b1;
    chk("R10 irq after reset", DATA_W'(irq_o), 0);
    brd(2, d, v);
    chk("R10 raw after reset", d, 16'h010);
    chk("R11 rvalid after read", DATA_W'(v), 1);
    brd(0, d, v);
    chk("R10 mask after reset", d, 0);

    bwr(3, 3);
    chk("R11 no rvalid after write", DATA_W'(bus_rvalid), 0);
    bwr(4, 5);
    for (int k = 0; k < NV; k++) begin
      brd(8, d, v);
      @(negedge clk);
      tx_level = VEC[k][25:19]; rx_level = VEC[k][18:12];
      pulse(VEC[k][37:26]);
      brd(2, d, v);
      chk($sformatf("R1 R2 R3 R9 vector %0d", k), d, DATA_W'(VEC[k][11:0]));
    end

    // masking
    brd(8, d, v);
    tx_level = 7'd10; rx_level = 7'd0;
    bwr(0, 12'h002);
    chk("R4 nothing pending", DATA_W'(irq_o), 0);
    pulse(12'h003);
    chk("R4 irq raised", DATA_W'(irq_o), 1);
    brd(1, d, v);
    chk("R4 masked status", d, 16'h002);
    bwr(0, 0);
    chk("R4 zero mask silences irq", DATA_W'(irq_o), 0);

    // per-source clear
    bwr(0, 12'h0F0);
    brd(16 + 1, d, v);
    chk("R7 clear read returns zero", d, 0);
    brd(2, d, v);
    chk("R6 single clear", d, 16'h001);
    brd(0, d, v);
    chk("R7 mask untouched", d, 16'h0F0);
    brd(3, d, v);
    chk("R7 threshold untouched", d, 16'h003);
    tx_level = 7'd0;
    brd(16 + 4, d, v);
    brd(2, d, v);
    chk("R6 level bit not clearable", d, 16'h011);

    // collisions
    clr_with_evt(16 + 0, 12'h001);
    brd(2, d, v);
    chk("R8 event beats single clear", d, 16'h011);
    pulse(12'h020);
    clr_with_evt(8, 12'h800);
    brd(2, d, v);
    chk("R8 R5 event beats clear-all", d, 16'h810);

    // receive threshold extremes
    brd(8, d, v);
    tx_level = 7'd10;
    bwr(4, 127); rx_level = 7'd127;
    brd(2, d, v);
    chk("R3 max threshold never full", d, 0);
    bwr(4, 0); rx_level = 7'd1;
    brd(2, d, v);
    chk("R3 zero threshold one entry", d, 16'h004);
    brd(8, d, v);
    brd(2, d, v);
    chk("R5 clear-all keeps level bit", d, 16'h004);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule